// File: doc/BRIEF.md
# Vectored Interrupt Priority Tracker

This block holds the pending and in-service state of 256 interrupt vectors, each state in its own 256-bit array. Each array is stored as eight 32-bit words. A vector `v` lives in word `v/32` at bit `v%32`. For each array the block continuously reports the highest set vector and a valid flag. From the two results it raises a ready flag toward the processor core.

Vectors arrive on a one-per-cycle request port and become pending. The core takes an interrupt by pulsing `take`, which moves the best pending vector into service. It finishes the handler by pulsing `done`, which retires the best in-service vector. Software-style inspection uses a combinational read port that returns any one of the eight words of either array.

Priority class is the upper nibble of a vector. A pending vector interrupts the core only if its class is above the class of the best vector already in service.

Top module: `irq_tracker`

## Requirements
- R1: After a synchronous active-high reset, both arrays are all zero, both valid flags are low, both vector outputs are 0, and `irq_ready` is low.
- R2: A cycle with `req_valid` high sets bit `req_vec%32` of pending word `req_vec/32`, visible after the next clock edge. No other bit changes.
- R3: `pend_vec` and `svc_vec` give the highest set vector of their array. That value is 32 × (index of the topmost non-zero word) + (position of the most significant set bit in that word).
- R4: When an array has no bit set, its valid flag (`pend_valid` / `svc_valid`) is low and its vector output is 0.
- R5: A cycle with `take` high and `pend_valid` high clears the pending bit of `pend_vec` and sets its in-service bit at the same edge. `take` with nothing pending changes nothing.
- R6: A cycle with `done` high and `svc_valid` high clears only the in-service bit of `svc_vec`. `done` with nothing in service changes nothing.
- R7: `irq_ready` is high exactly when `pend_valid` is high and either `svc_valid` is low or `pend_vec[7:4]` > `svc_vec[7:4]`.
- R8: A request and a `take` that name the same vector in one cycle leave that vector pending, and it also enters service.
- R9: `rd_data` returns pending word `rd_word` when `rd_sel` is 0 and in-service word `rd_word` when `rd_sel` is 1, combinationally from current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_vec | input | 8 | Vector being requested |
| take | input | 1 | Core accepts the best pending vector |
| done | input | 1 | End of interrupt for the best in-service vector |
| rd_sel | input | 1 | Read array select: 0 pending, 1 in-service |
| rd_word | input | 3 | Read word index |
| rd_data | output | 32 | Selected 32-bit word |
| pend_valid | output | 1 | Some vector is pending |
| pend_vec | output | 8 | Highest pending vector |
| svc_valid | output | 1 | Some vector is in service |
| svc_vec | output | 8 | Highest in-service vector |
| irq_ready | output | 1 | Interrupt should be presented to the core |

## Verification
The bench walks every one of the 256 vectors through request, take and done. A wrong word/bit split, or an off-by-one in the top-down scan, therefore shows up as a wrong word on the read port or a wrong reported vector. Nested handlers check class comparison on the nibble boundary. There, a full-vector compare, or a `>=` in place of `>`, would raise `irq_ready` for a same-class vector. A `done` must drop only the top in-service bit; a design that clears the whole word would lose the outer handler. A request colliding with a take of the same vector must survive; a clear-wins design would silently drop it. A long pseudo-random mix, compared against an arithmetic model, catches cross-word interference.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
    localparam int VEC_COUNT  = 256;
    localparam int WORD_W     = 32;
    localparam int NUM_WORDS  = VEC_COUNT / WORD_W;
    localparam int VEC_W      = $clog2(VEC_COUNT);
    localparam int BIT_W      = $clog2(WORD_W);
    localparam int WSEL_W     = $clog2(NUM_WORDS);
    localparam int CLASS_LSB  = 4;

    typedef logic [NUM_WORDS-1:0][WORD_W-1:0] vec_words_t;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
    } top_vec_t;

    typedef struct packed {
        logic             found;
        logic [BIT_W-1:0] pos;
    } word_msb_t;

    function automatic word_msb_t msb_in_word(input logic [WORD_W-1:0] w);
        word_msb_t r;
        r = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (w[i]) begin
                r.found = 1'b1;
                r.pos   = BIT_W'(i);
            end
        end
        return r;
    endfunction

    function automatic logic outranks(input top_vec_t p, input top_vec_t s);
        return p.valid && (!s.valid ||
               (p.vec[VEC_W-1:CLASS_LSB] > s.vec[VEC_W-1:CLASS_LSB]));
    endfunction
endpackage

// File: rtl/irq_vec_array.sv
module irq_vec_array
    import irq_trk_pkg::*;
#(
    parameter int NW = NUM_WORDS,
    parameter int WW = WORD_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           set_en,
    input  logic [$clog2(NW*WW)-1:0]       set_idx,
    input  logic                           clr_en,
    input  logic [$clog2(NW*WW)-1:0]       clr_idx,
    output logic [NW-1:0][WW-1:0]          words
);
    localparam int IDX_W = $clog2(NW * WW);
    localparam int BW    = $clog2(WW);
    localparam int WS_W  = IDX_W - BW;

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic          set_hit;
        logic          clr_hit;
        logic [WW-1:0] set_m;
        logic [WW-1:0] clr_m;
        logic [WW-1:0] word_q;

        always_comb begin
            set_hit = set_en && (set_idx[IDX_W-1:BW] == WS_W'(w));
            clr_hit = clr_en && (clr_idx[IDX_W-1:BW] == WS_W'(w));
            set_m   = set_hit ? (WW'(1) << set_idx[BW-1:0]) : '0;
            clr_m   = clr_hit ? (WW'(1) << clr_idx[BW-1:0]) : '0;
        end

        // set wins over clear on the same bit
        always_ff @(posedge clk) begin
            if (rst) word_q <= '0;
            else     word_q <= (word_q & ~clr_m) | set_m;
        end

        assign words[w] = word_q;
    end
endmodule

// File: rtl/irq_prio_find.sv
module irq_prio_find
    import irq_trk_pkg::*;
(
    input  vec_words_t words,
    output top_vec_t   best
);
    always_comb begin
        word_msb_t m;
        best = '0;
        // ascending scan: a higher non-zero word overrides lower ones
        for (int w = 0; w < NUM_WORDS; w++) begin
            m = msb_in_word(words[w]);
            if (m.found) begin
                best.valid = 1'b1;
                best.vec   = VEC_W'(w * WORD_W) | VEC_W'(m.pos);
            end
        end
    end
endmodule

// File: rtl/irq_tracker.sv
module irq_tracker
    import irq_trk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  req_vec,
    input  logic              take,
    input  logic              done,
    input  logic              rd_sel,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [WORD_W-1:0] rd_data,
    output logic              pend_valid,
    output logic [VEC_W-1:0]  pend_vec,
    output logic              svc_valid,
    output logic [VEC_W-1:0]  svc_vec,
    output logic              irq_ready
);
    vec_words_t pend_words;
    vec_words_t svc_words;
    top_vec_t   pend_best;
    top_vec_t   svc_best;
    logic       take_eff;
    logic       done_eff;

    assign take_eff = take && pend_best.valid;
    assign done_eff = done && svc_best.valid;

    irq_vec_array #(.NW(NUM_WORDS), .WW(WORD_W)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_en  (req_valid),
        .set_idx (req_vec),
        .clr_en  (take_eff),
        .clr_idx (pend_best.vec),
        .words   (pend_words)
    );

    irq_vec_array #(.NW(NUM_WORDS), .WW(WORD_W)) u_svc (
        .clk     (clk),
        .rst     (rst),
        .set_en  (take_eff),
        .set_idx (pend_best.vec),
        .clr_en  (done_eff),
        .clr_idx (svc_best.vec),
        .words   (svc_words)
    );

    irq_prio_find u_find_pend (.words(pend_words), .best(pend_best));
    irq_prio_find u_find_svc  (.words(svc_words),  .best(svc_best));

    assign pend_valid = pend_best.valid;
    assign pend_vec   = pend_best.vec;
    assign svc_valid  = svc_best.valid;
    assign svc_vec    = svc_best.vec;
    assign irq_ready  = outranks(pend_best, svc_best);
    assign rd_data    = rd_sel ? svc_words[rd_word] : pend_words[rd_word];
endmodule

// File: rtl/irq_tracker_chk.sv
module irq_tracker_chk
    import irq_trk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [VEC_W-1:0] req_vec,
    input logic             take,
    input logic             done,
    input logic             pend_valid,
    input logic [VEC_W-1:0] pend_vec,
    input logic             svc_valid,
    input logic [VEC_W-1:0] svc_vec,
    input logic             irq_ready
);
    AST_REQ_LANDS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> pend_valid && (pend_vec >= $past(req_vec))); // R2

    AST_PEND_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
        !pend_valid |-> (pend_vec == '0)); // R4

    AST_SVC_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
        !svc_valid |-> (svc_vec == '0)); // R4

    AST_TAKE_ENTERS: assert property (@(posedge clk) disable iff (rst)
        (take && pend_valid) |=> svc_valid && (svc_vec >= $past(pend_vec))); // R5

    AST_TAKE_LEAVES: assert property (@(posedge clk) disable iff (rst)
        (take && pend_valid && !(req_valid && req_vec == pend_vec))
        |=> (!pend_valid || pend_vec != $past(pend_vec))); // R5

    AST_DONE_DROPS: assert property (@(posedge clk) disable iff (rst)
        (done && svc_valid && !take)
        |=> (!svc_valid || svc_vec < $past(svc_vec))); // R6

    AST_READY_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        irq_ready |-> pend_valid); // R7

    AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (take && pend_valid && req_valid && req_vec == pend_vec)
        |=> pend_valid && (pend_vec >= $past(pend_vec))); // R8
endmodule

bind irq_tracker irq_tracker_chk u_chk (.*);

// File: tb/tb_irq_tracker.sv
`timescale 1ns/1ps
module tb_irq_tracker;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [7:0]  req_vec;
    logic        take;
    logic        done;
    logic        rd_sel;
    logic [2:0]  rd_word;
    logic [31:0] rd_data;
    logic        pend_valid;
    logic [7:0]  pend_vec;
    logic        svc_valid;
    logic [7:0]  svc_vec;
    logic        irq_ready;

    int checks = 0;
    int fails  = 0;

    logic [255:0] pend_m;
    logic [255:0] svc_m;

    always #2.5 clk = ~clk;

    irq_tracker dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vec(req_vec),
        .take(take), .done(done), .rd_sel(rd_sel), .rd_word(rd_word),
        .rd_data(rd_data), .pend_valid(pend_valid), .pend_vec(pend_vec),
        .svc_valid(svc_valid), .svc_vec(svc_vec), .irq_ready(irq_ready)
    );

    function automatic logic [8:0] top_of(input logic [255:0] a);
        logic [8:0] r;
        r = '0;
        for (int i = 0; i < 256; i++) if (a[i]) r = {1'b1, 8'(i)};
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compares every output and all sixteen words against the model
    task automatic check_state(input string tag);
        logic [8:0] p;
        logic [8:0] s;
        logic       rdy;
        p   = top_of(pend_m);
        s   = top_of(svc_m);
        rdy = p[8] && (!s[8] || p[7:4] > s[7:4]);
        chk(pend_valid == p[8], {tag, " R4 pend_valid"}, 32'(pend_valid), 32'(p[8]));
        chk(pend_vec == p[7:0], {tag, " R3 pend_vec"}, 32'(pend_vec), 32'(p[7:0]));
        chk(svc_valid == s[8], {tag, " R4 svc_valid"}, 32'(svc_valid), 32'(s[8]));
        chk(svc_vec == s[7:0], {tag, " R3 svc_vec"}, 32'(svc_vec), 32'(s[7:0]));
        chk(irq_ready == rdy, {tag, " R7 irq_ready"}, 32'(irq_ready), 32'(rdy));
        for (int w = 0; w < 8; w++) begin
            rd_sel = 1'b0; rd_word = 3'(w); #0.1;
            chk(rd_data == pend_m[w*32 +: 32], {tag, " R9 pend word"}, rd_data, pend_m[w*32 +: 32]);
            rd_sel = 1'b1; #0.1;
            chk(rd_data == svc_m[w*32 +: 32], {tag, " R9 svc word"}, rd_data, svc_m[w*32 +: 32]);
        end
    endtask

    // called at a negedge; returns at the following negedge with the model updated
    task automatic step(input bit r, input logic [7:0] v, input bit t, input bit d);
        logic [8:0] p;
        logic [8:0] s;
        logic [255:0] tmask;
        logic [255:0] dmask;
        logic [255:0] rmask;
        p = top_of(pend_m);
        s = top_of(svc_m);
        tmask = (t && p[8]) ? (256'(1) << p[7:0]) : '0;
        dmask = (d && s[8]) ? (256'(1) << s[7:0]) : '0;
        rmask = r ? (256'(1) << v) : '0;
        req_valid = r; req_vec = v; take = t; done = d;
        @(posedge clk);
        @(negedge clk);
        pend_m = (pend_m & ~tmask) | rmask;
        svc_m  = (svc_m & ~dmask) | tmask;
        req_valid = 1'b0; take = 1'b0; done = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        rst = 1'b1; req_valid = 1'b0; req_vec = '0; take = 1'b0; done = 1'b0;
        rd_sel = 1'b0; rd_word = '0;
        pend_m = '0; svc_m = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_state("R1 reset");

        // R2 R3 R5 R6: every vector through request, take, done
        for (int v = 0; v < 256; v++) begin
            step(1'b1, 8'(v), 1'b0, 1'b0);
            check_state("R2 request");
            step(1'b0, 8'h00, 1'b1, 1'b0);
            check_state("R5 take");
            step(1'b0, 8'h00, 1'b0, 1'b1);
            check_state("R6 done");
        end

        // R5 R6: take and done on empty arrays change nothing
        step(1'b0, 8'h00, 1'b1, 1'b1);
        check_state("R5 R6 empty take/done");

        // R7 nesting on class boundary
        step(1'b1, 8'h35, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        step(1'b1, 8'h3A, 1'b0, 1'b0);
        check_state("R7 same class");
        chk(irq_ready == 1'b0, "R7 same class blocks", 32'(irq_ready), 32'd0);
        step(1'b1, 8'h41, 1'b0, 1'b0);
        chk(irq_ready == 1'b1, "R7 higher class", 32'(irq_ready), 32'd1);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        check_state("R7 nested take");
        step(1'b0, 8'h00, 1'b0, 1'b1);
        check_state("R6 inner done");
        chk(svc_vec == 8'h35, "R6 outer kept", 32'(svc_vec), 32'h35);

        // R8 collision of request and take on the same vector
        step(1'b1, 8'h80, 1'b0, 1'b0);
        step(1'b1, 8'h80, 1'b1, 1'b0);
        check_state("R8 collide");
        chk(pend_vec == 8'h80 && pend_valid, "R8 stays pending", 32'(pend_vec), 32'h80);

        // mixed pseudo-random traffic
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[15:8], lfsr[3:1] == 3'b101, lfsr[6:4] == 3'b011);
            if (n % 16 == 0) check_state("R2 R3 R5 R6 mix");
            else begin
                logic [8:0] p;
                p = top_of(pend_m);
                chk(pend_vec == p[7:0], "R3 mix pend_vec", 32'(pend_vec), 32'(p[7:0]));
            end
        end

        // R1 reset from a busy state
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        pend_m = '0; svc_m = '0;
        check_state("R1 re-reset");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule